// File: doc/BRIEF.md
# Sequencer Step Clock Source and Edge Selector

This block decides which clock paces a pattern sequencer's steps. It turns that clock into a strobe that lasts one cycle of a fast sampling clock. Sixteen sources can be selected: the sequencer's own internal period tick, twelve auxiliary external lines, a backplane trigger line, an internal pulse generator and an internal frequency synthesizer. Every source other than the internal tick arrives asynchronously. Each such line passes through a two-flop synchronizer. An edge stage then forms the active edge in one of five ways: rising, falling, both edges, or the rising or falling edge of a copy of the input halved in frequency.

The source and mode settings are loaded together through a single write strobe. A small state machine then keeps the output quiet while the edge history settles. The state machine has three states: ST_SETTLE_A, ST_SETTLE_B and ST_LIVE. Reset and every configuration write send it to ST_SETTLE_A. It always moves from ST_SETTLE_A to ST_SETTLE_B, and from ST_SETTLE_B to ST_LIVE. It stays in ST_LIVE until the next write. Strobes are issued only from ST_LIVE. In the two settling states the edge-history flop copies the synchronized input, so a level that is already present is not taken for an edge. The sampling clock must run at least four times faster than the fastest external input.

Top module: `stepclk_select`

## Requirements
- R1: The source code `cfg_src` selects the step clock as follows. Code 0 selects `period_tick`. Codes 1 to 12 select `aux_in[code-1]`. Code 13 selects `bp_trig`, code 14 selects `pulse_in` and code 15 selects `synth_in`. Activity on lines that are not selected produces no strobe.
- R2: With source code 0, `cfg_mode` has no effect. A `period_tick` level sampled high at a clock edge in ST_LIVE gives `step_strobe` high in the cycle after that edge, once for each cycle the tick is high.
- R3: For an external source, a change applied before clock edge k shows up as `step_strobe` high in the cycle that follows edge k+2, and low in the cycles before and after.
- R4: Mode code 0 strobes once on each low-to-high transition of the selected input. Mode codes 5, 6 and 7 behave exactly like code 0.
- R5: Mode code 1 strobes once on each high-to-low transition.
- R6: Mode code 2 strobes on every transition, giving two strobes per input period.
- R7: Mode code 3 strobes on the 1st, 3rd, 5th and later odd-numbered rising transitions after a configuration write.
- R8: Mode code 4 strobes on the 2nd, 4th and later even-numbered rising transitions after a configuration write.
- R9: Source codes 16 to 31 select nothing, and `step_strobe` stays low.
- R10: A write (`cfg_wr` high at a clock edge) has three effects:
  - it forces `step_strobe` low for the three cycles that follow that edge;
  - it clears the divide-by-two state;
  - it leaves no edge pending for a level that was already present or that changed during the write.
- R11: For external sources, `step_strobe` is never high in two consecutive cycles.
- R12: After reset, the source is code 0 and the mode is code 0. The state machine starts in ST_SETTLE_A, so `step_strobe` stays low in the first two cycles after reset is released, even if `period_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load `cfg_src` and `cfg_mode` |
| cfg_src | input | 5 | Source code (see R1, R9) |
| cfg_mode | input | 3 | Edge-mode code (see R4 to R8) |
| period_tick | input | 1 | Internal sequencer period tick, synchronous to `clk` |
| aux_in | input | 12 | Auxiliary external clock lines |
| bp_trig | input | 1 | Backplane trigger clock line |
| pulse_in | input | 1 | Internal pulse generator output |
| synth_in | input | 1 | Internal frequency synthesizer output |
| step_strobe | output | 1 | One-cycle active-edge strobe |

## Verification
The bound checker checks on every cycle that the output is silent during a write and during both settling states, and that an unused source code never produces a strobe. It also checks that the tick path follows the tick one cycle later, and that external strobes are never wider than one cycle. The directed scenarios are needed for the parts that depend on a sequence of input edges. These are the exact synchronizer latency, the strobe counts per pulse train in each of the five modes, the odd and even parity of the divided modes, and the mapping of source codes to input lines. The scenarios also show that a write clears the divider and swallows an edge that arrives during the write.

// File: rtl/stepclk_pkg.sv
package stepclk_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] EDGE_RISE     = 3'd0;
    localparam logic [MODE_W-1:0] EDGE_FALL     = 3'd1;
    localparam logic [MODE_W-1:0] EDGE_BOTH     = 3'd2;
    localparam logic [MODE_W-1:0] EDGE_DIV_RISE = 3'd3;
    localparam logic [MODE_W-1:0] EDGE_DIV_FALL = 3'd4;

    typedef enum logic [1:0] {
        ST_SETTLE_A = 2'd0,
        ST_SETTLE_B = 2'd1,
        ST_LIVE     = 2'd2
    } gate_state_e;

endpackage

// File: rtl/stepclk_sync_bank.sv
module stepclk_sync_bank #(
    parameter int WIDTH  = 15,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[i]};
            end
        end

        assign sync_out[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/stepclk_src_mux.sv
module stepclk_src_mux #(
    parameter int NUM_EXT = 15,
    parameter int SRC_W   = 5
) (
    input  logic [SRC_W-1:0]   sel,
    input  logic [NUM_EXT-1:0] ext_sync,
    output logic               ext_bit,
    output logic               use_tick,
    output logic               src_valid
);

    always_comb begin
        ext_bit = 1'b0;
        for (int i = 0; i < NUM_EXT; i++) begin
            if (sel == SRC_W'(i + 1)) begin
                ext_bit = ext_sync[i];
            end
        end
    end

    assign use_tick  = (sel == '0);
    assign src_valid = (int'(sel) <= NUM_EXT);

endmodule

// File: rtl/stepclk_edge_unit.sv
module stepclk_edge_unit
    import stepclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              track,
    input  logic              sample,
    input  logic [MODE_W-1:0] mode,
    output logic              event_o
);

    logic prev_q;
    logic half_q;
    logic rise;
    logic fall;

    assign rise = sample & ~prev_q;
    assign fall = ~sample & prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_q <= 1'b0;
            half_q <= 1'b0;
        end else begin
            prev_q <= sample;
            if (!track && rise) begin
                half_q <= ~half_q;
            end
        end
    end

    always_comb begin
        case (mode)
            EDGE_RISE:     event_o = rise;
            EDGE_FALL:     event_o = fall;
            EDGE_BOTH:     event_o = rise | fall;
            EDGE_DIV_RISE: event_o = rise & ~half_q;
            EDGE_DIV_FALL: event_o = rise & half_q;
            default:       event_o = rise;
        endcase
    end

endmodule

// File: rtl/stepclk_select.sv
module stepclk_select
    import stepclk_pkg::*;
#(
    parameter int NUM_AUX     = 12,
    parameter int SYNC_STAGES = 2,
    parameter int SRC_W       = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic [MODE_W-1:0]  cfg_mode,
    input  logic               period_tick,
    input  logic [NUM_AUX-1:0] aux_in,
    input  logic               bp_trig,
    input  logic               pulse_in,
    input  logic               synth_in,
    output logic               step_strobe
);

    localparam int NUM_EXT = NUM_AUX + 3;

    logic [SRC_W-1:0]   src_q;
    logic [MODE_W-1:0]  mode_q;
    gate_state_e        state_q;
    gate_state_e        state_d;
    logic [NUM_EXT-1:0] ext_raw;
    logic [NUM_EXT-1:0] ext_sync;
    logic               ext_bit;
    logic               use_tick;
    logic               src_valid;
    logic               edge_evt;
    logic               raw_evt;

    assign ext_raw = {synth_in, pulse_in, bp_trig, aux_in};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            mode_q <= EDGE_RISE;
        end else if (cfg_wr) begin
            src_q  <= cfg_src;
            mode_q <= cfg_mode;
        end
    end

    stepclk_sync_bank #(.WIDTH(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_raw),
        .sync_out (ext_sync)
    );

    stepclk_src_mux #(.NUM_EXT(NUM_EXT), .SRC_W(SRC_W)) u_mux (
        .sel       (src_q),
        .ext_sync  (ext_sync),
        .ext_bit   (ext_bit),
        .use_tick  (use_tick),
        .src_valid (src_valid)
    );

    stepclk_edge_unit u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cfg_wr),
        .track   (state_q != ST_LIVE),
        .sample  (ext_bit),
        .mode    (mode_q),
        .event_o (edge_evt)
    );

    assign raw_evt = use_tick ? period_tick : (src_valid & edge_evt);

    always_comb begin
        if (cfg_wr) begin
            state_d = ST_SETTLE_A;
        end else begin
            unique case (state_q)
                ST_SETTLE_A: state_d = ST_SETTLE_B;
                ST_SETTLE_B: state_d = ST_LIVE;
                ST_LIVE:     state_d = ST_LIVE;
                default:     state_d = ST_SETTLE_A;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE_A;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_strobe <= 1'b0;
        end else begin
            step_strobe <= !cfg_wr && (state_q == ST_LIVE) && raw_evt;
        end
    end

endmodule

// File: rtl/stepclk_select_chk.sv
module stepclk_select_chk
    import stepclk_pkg::*;
#(
    parameter int NUM_EXT = 15,
    parameter int SRC_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             period_tick,
    input logic [SRC_W-1:0] src_q,
    input gate_state_e      state_q,
    input logic             step_strobe
);

    AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !step_strobe); // R10

    AST_SETTLE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LIVE) |=> !step_strobe); // R12

    AST_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(src_q) > NUM_EXT) |=> !step_strobe); // R9

    AST_TICK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == '0 && state_q == ST_LIVE && !cfg_wr) |=> (step_strobe == $past(period_tick))); // R2

    AST_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q != '0 && step_strobe) |=> !step_strobe); // R11

endmodule

bind stepclk_select stepclk_select_chk #(.NUM_EXT(NUM_EXT), .SRC_W(SRC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .period_tick (period_tick),
    .src_q       (src_q),
    .state_q     (state_q),
    .step_strobe (step_strobe)
);

// File: tb/stepclk_select_test.sv
module stepclk_select_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_src = '0;
    logic [2:0]  cfg_mode = '0;
    logic        period_tick = 1'b0;
    logic [14:0] ext_drv = '0;
    logic        step_strobe;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    bit saw_wide = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stepclk_select uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_src     (cfg_src),
        .cfg_mode    (cfg_mode),
        .period_tick (period_tick),
        .aux_in      (ext_drv[11:0]),
        .bp_trig     (ext_drv[12]),
        .pulse_in    (ext_drv[13]),
        .synth_in    (ext_drv[14]),
        .step_strobe (step_strobe)
    );

    task automatic check(input string req, input int actual, input int expected, input string what);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic configure(input logic [4:0] src, input logic [2:0] mode);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_src = src;
        cfg_mode = mode;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic count_strobes(input int cycles, inout int cnt);
        bit prev_s = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (step_strobe) cnt++;
            if (prev_s && step_strobe) saw_wide = 1'b1;
            prev_s = step_strobe;
        end
    endtask

    task automatic pulse_train(input int bit_idx, input int periods, output int cnt);
        cnt = 0;
        for (int p = 0; p < periods; p++) begin
            ext_drv[bit_idx] = 1'b1;
            count_strobes(4, cnt);
            ext_drv[bit_idx] = 1'b0;
            count_strobes(4, cnt);
        end
        count_strobes(6, cnt);
    endtask

    task automatic t_reset;
        period_tick = 1'b1;
        repeat (3) @(negedge clk);
        check("R12", int'(step_strobe), 0, "strobe during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", int'(step_strobe), 0, "strobe first cycle after reset");
        @(negedge clk);
        check("R12", int'(step_strobe), 0, "strobe second cycle after reset");
        @(negedge clk);
        check("R12", int'(step_strobe), 1, "default tick source strobe");
        period_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_tick;
        int cnt;
        configure(5'd0, 3'd2);
        period_tick = 1'b1;
        @(negedge clk);
        check("R2", int'(step_strobe), 1, "tick strobe with mode ignored");
        period_tick = 1'b0;
        @(negedge clk);
        check("R2", int'(step_strobe), 0, "tick strobe after tick low");
        cnt = 0;
        period_tick = 1'b1;
        count_strobes(3, cnt);
        period_tick = 1'b0;
        count_strobes(2, cnt);
        check("R2", cnt, 3, "strobes for three-cycle tick");
        pulse_train(0, 2, cnt);
        check("R1", cnt, 0, "aux activity with tick selected");
    endtask

    task automatic t_latency;
        configure(5'd3, 3'd0);
        ext_drv[2] = 1'b1;
        @(negedge clk);
        check("R3", int'(step_strobe), 0, "strobe after edge k");
        @(negedge clk);
        check("R3", int'(step_strobe), 0, "strobe after edge k+1");
        @(negedge clk);
        check("R3", int'(step_strobe), 1, "strobe after edge k+2");
        @(negedge clk);
        check("R3", int'(step_strobe), 0, "strobe after edge k+3");
        ext_drv[2] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_modes;
        int cnt;
        configure(5'd5, 3'd0);
        pulse_train(4, 3, cnt);
        check("R4", cnt, 3, "rising mode strobes");
        configure(5'd5, 3'd6);
        pulse_train(4, 3, cnt);
        check("R4", cnt, 3, "mode 6 behaves as rising");
        configure(5'd5, 3'd1);
        pulse_train(4, 3, cnt);
        check("R5", cnt, 3, "falling mode strobes");
        saw_wide = 1'b0;
        configure(5'd5, 3'd2);
        pulse_train(4, 4, cnt);
        check("R6", cnt, 8, "both-edge mode strobes");
        check("R11", int'(saw_wide), 0, "strobe wider than one cycle");
        configure(5'd5, 3'd3);
        pulse_train(4, 3, cnt);
        check("R7", cnt, 2, "divide rising strobes on odd rises");
        configure(5'd5, 3'd4);
        pulse_train(4, 3, cnt);
        check("R8", cnt, 1, "divide falling strobes on even rises");
    endtask

    task automatic t_select;
        int cnt;
        configure(5'd13, 3'd0);
        pulse_train(12, 2, cnt);
        check("R1", cnt, 2, "backplane line code 13");
        pulse_train(0, 2, cnt);
        check("R1", cnt, 0, "unselected aux with code 13");
        configure(5'd14, 3'd0);
        pulse_train(13, 2, cnt);
        check("R1", cnt, 2, "pulse generator code 14");
        configure(5'd15, 3'd0);
        pulse_train(14, 3, cnt);
        check("R1", cnt, 3, "synthesizer code 15");
        configure(5'd12, 3'd0);
        pulse_train(11, 1, cnt);
        check("R1", cnt, 1, "last aux code 12");
    endtask

    task automatic t_invalid;
        int cnt;
        int total = 0;
        configure(5'd20, 3'd2);
        for (int b = 0; b < 15; b++) begin
            pulse_train(b, 1, cnt);
            total += cnt;
        end
        check("R9", total, 0, "strobes with code 20");
        configure(5'd31, 3'd0);
        pulse_train(14, 2, cnt);
        check("R9", cnt, 0, "strobes with code 31");
    endtask

    task automatic t_write_blank;
        int cnt;
        configure(5'd1, 3'd0);
        @(negedge clk);
        cfg_wr = 1'b1;
        ext_drv[0] = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cnt = 0;
        count_strobes(10, cnt);
        check("R10", cnt, 0, "edge during write swallowed");
        configure(5'd1, 3'd0);
        cnt = 0;
        count_strobes(6, cnt);
        check("R10", cnt, 0, "held level after write");
        ext_drv[0] = 1'b0;
        repeat (4) @(negedge clk);
        configure(5'd1, 3'd3);
        pulse_train(0, 1, cnt);
        check("R7", cnt, 1, "first divided rise strobes");
        configure(5'd1, 3'd3);
        pulse_train(0, 1, cnt);
        check("R10", cnt, 1, "divider cleared by write");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_tick();
        t_latency();
        t_modes();
        t_select();
        t_invalid();
        t_write_blank();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule